// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block sits beside the register file of a serial port and turns a set of pending conditions into one interrupt request line and an identification byte. Five condition groups compete for the line: receive line errors, a receive character timeout, received data, an empty transmit holding register and modem status changes. A four-bit enable register, written by software, gates each group. The highest-ranked source that is both pending and enabled supplies a 4-bit code in the low nibble of the identification byte, and the upper bits report whether the FIFOs are switched on.

The transmit-empty source is not a plain level. It is held in a pending flag of its own. A byte written to the transmit holding register clears the flag. The transmitter sets it when the holding register becomes empty. Reading the identification byte while it shows the transmit-empty code clears it. Changing the transmit-empty enable bit samples the empty flag again. The FIFOs, timers and shifters live elsewhere and only their status reaches this block.

Both outputs are registered. They reflect any change at the inputs or any register access on the next clock edge.

Top module: `uart_int_prioritizer`

## Requirements
- R1: A synchronous active-high reset leaves the enable register at 0, the identification byte at 0x01, the interrupt line low and the transmit-empty pending flag clear.
- R2: A pulse on `en_wr` loads the low four bits of `en_wdata` into the enable register, which shows on `int_en` from the next cycle. Bit 0 is receive data, bit 1 is transmit empty, bit 2 is line status and bit 3 is modem status.
- R3: The codes rank as follows, highest first: line status 0x6, character timeout 0xC, received data 0x4, transmit empty 0x2, modem status 0x0. With nothing enabled and pending, the low nibble is 0x1.
- R4: The line status source is active when enable bit 2 is set and any bit of `lsr_err` (overrun, parity, framing, break) is set.
- R5: The character timeout source is active when `tmo_pend` is set and enable bit 0 is set. It has no enable of its own.
- R6: The received data source needs `data_rdy` and enable bit 0. With `fifo_on` high, it also needs `rx_count >= rx_trig`. With `fifo_on` low, data ready alone is enough.
- R7: The transmit-empty pending flag sets on a rising edge of `thr_empty` and clears on a `thr_wr` pulse. The source is active when the flag and enable bit 1 are both set.
- R8: An `id_rd` pulse while `int_id[3:0]` shows 0x2 clears the pending flag. A read showing any other code leaves the flag as it is.
- R9: An enable write that changes bit 1 sets the pending flag if the new bit 1 is 1 and `thr_empty` is 1, and clears it otherwise. An enable write that keeps bit 1 does not touch the flag. On the flag, this rule takes precedence over R7, and R7 takes precedence over R8.
- R10: `int_id[7:4]` is 0xC while `fifo_on` is high and 0x0 otherwise.
- R11: `irq` is high exactly when `int_id[3:0]` is not 0x1. Both outputs follow the inputs of the previous cycle.
- R12: The modem status source is active when enable bit 3 is set and any bit of `msr_delta` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 4 | Enable register write data |
| id_rd | input | 1 | Read strobe of the identification byte |
| thr_wr | input | 1 | Write strobe of the transmit holding register |
| fifo_on | input | 1 | FIFOs enabled |
| lsr_err | input | 4 | Receive error flags: break, framing, parity, overrun |
| data_rdy | input | 1 | Receive data ready |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_trig | input | CNT_W | Receive FIFO trigger level |
| tmo_pend | input | 1 | Character timeout pending |
| thr_empty | input | 1 | Transmit holding register empty |
| msr_delta | input | 4 | Modem status change flags |
| int_en | output | 4 | Enable register contents |
| int_id | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The sources are tried first one at a time, each with its enable on and then off. These runs separate the gating of each source from its ranking, and show that the timeout follows the receive-data enable. Receive data is then driven with the FIFOs on and off and with the fill level below, at and above the trigger, so an off-by-one in the compare stands out. Scripted sequences on the transmit-empty flag combine holding-register writes, identification reads that show and do not show code 0x2, and enable writes that do and do not change bit 1. All sources are then raised together and dropped one by one to expose the ranking. A long random stretch mixes every strobe so that the precedence among flag updates in the same cycle is compared against a reference model.

// File: rtl/uart_int_pkg.sv
package uart_int_pkg;
  localparam int EN_W   = 4;
  localparam int ERR_W  = 4;
  localparam int MDM_W  = 4;
  localparam int ID_W   = 8;
  localparam int CODE_W = 4;
  localparam int NUM_SRC = 5;

  typedef enum logic [CODE_W-1:0] {
    CODE_MODEM   = 4'h0,
    CODE_NONE    = 4'h1,
    CODE_THRE    = 4'h2,
    CODE_RXDATA  = 4'h4,
    CODE_LINE    = 4'h6,
    CODE_TIMEOUT = 4'hC
  } int_code_e;

  // enable register bit positions
  localparam int EN_RX   = 0;
  localparam int EN_TX   = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;

  // index 0 is the highest priority
  function automatic int_code_e src_code(input int idx);
    case (idx)
      0:       return CODE_LINE;
      1:       return CODE_TIMEOUT;
      2:       return CODE_RXDATA;
      3:       return CODE_THRE;
      default: return CODE_MODEM;
    endcase
  endfunction

  localparam logic [3:0] FIFO_TAG = 4'hC;
endpackage

// File: rtl/uart_int_enable.sv
module uart_int_enable
  import uart_int_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [EN_W-1:0] wdata,
  output logic [EN_W-1:0] en_q,
  output logic [EN_W-1:0] en_next,
  output logic            tx_bit_toggled
);
  always_comb begin
    en_next = wr ? wdata : en_q;
  end

  assign tx_bit_toggled = wr && (wdata[EN_TX] != en_q[EN_TX]);

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_next;
  end
endmodule

// File: rtl/uart_int_thre_latch.sv
module uart_int_thre_latch (
  input  logic clk,
  input  logic rst,
  input  logic rearm,
  input  logic rearm_en,
  input  logic thr_empty,
  input  logic thr_wr,
  input  logic rd_clear,
  output logic pend_q,
  output logic pend_next
);
  logic empty_prev;
  logic empty_rise;

  assign empty_rise = thr_empty && !empty_prev;

  always_comb begin
    pend_next = pend_q;
    if (rearm)           pend_next = rearm_en && thr_empty;
    else if (thr_wr)     pend_next = 1'b0;
    else if (empty_rise) pend_next = 1'b1;
    else if (rd_clear)   pend_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      empty_prev <= 1'b1;
    end else begin
      pend_q     <= pend_next;
      empty_prev <= thr_empty;
    end
  end
endmodule

// File: rtl/uart_int_encoder.sv
module uart_int_encoder
  import uart_int_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [EN_W-1:0]  en,
  input  logic             tx_pend,
  input  logic [ERR_W-1:0] lsr_err,
  input  logic             data_rdy,
  input  logic             fifo_on,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             tmo_pend,
  input  logic [MDM_W-1:0] msr_delta,
  output int_code_e        code
);
  logic [NUM_SRC-1:0] req;
  logic               level_met;

  assign level_met = !fifo_on || (rx_count >= rx_trig);

  assign req[0] = en[EN_LINE] && (|lsr_err);
  assign req[1] = en[EN_RX]   && tmo_pend;
  assign req[2] = en[EN_RX]   && data_rdy && level_met;
  assign req[3] = en[EN_TX]   && tx_pend;
  assign req[4] = en[EN_MDM]  && (|msr_delta);

  always_comb begin
    code = CODE_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) code = src_code(i);
    end
  end
endmodule

// File: rtl/uart_int_prioritizer.sv
module uart_int_prioritizer
  import uart_int_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_wr,
  input  logic [3:0]       en_wdata,
  input  logic             id_rd,
  input  logic             thr_wr,
  input  logic             fifo_on,
  input  logic [3:0]       lsr_err,
  input  logic             data_rdy,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             tmo_pend,
  input  logic             thr_empty,
  input  logic [3:0]       msr_delta,
  output logic [3:0]       int_en,
  output logic [7:0]       int_id,
  output logic             irq
);
  logic [EN_W-1:0] en_q;
  logic [EN_W-1:0] en_next;
  logic            tx_toggle;
  logic            pend_q;
  logic            pend_next;
  logic            rd_clear;
  int_code_e       code;
  logic [ID_W-1:0] id_q;
  logic            irq_q;

  uart_int_enable u_enable (
    .clk            (clk),
    .rst            (rst),
    .wr             (en_wr),
    .wdata          (en_wdata),
    .en_q           (en_q),
    .en_next        (en_next),
    .tx_bit_toggled (tx_toggle)
  );

  assign rd_clear = id_rd && (id_q[CODE_W-1:0] == CODE_THRE);

  uart_int_thre_latch u_thre (
    .clk       (clk),
    .rst       (rst),
    .rearm     (tx_toggle),
    .rearm_en  (en_next[EN_TX]),
    .thr_empty (thr_empty),
    .thr_wr    (thr_wr),
    .rd_clear  (rd_clear),
    .pend_q    (pend_q),
    .pend_next (pend_next)
  );

  uart_int_encoder #(.CNT_W(CNT_W)) u_enc (
    .en        (en_next),
    .tx_pend   (pend_next),
    .lsr_err   (lsr_err),
    .data_rdy  (data_rdy),
    .fifo_on   (fifo_on),
    .rx_count  (rx_count),
    .rx_trig   (rx_trig),
    .tmo_pend  (tmo_pend),
    .msr_delta (msr_delta),
    .code      (code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q  <= {{(ID_W-CODE_W){1'b0}}, CODE_NONE};
      irq_q <= 1'b0;
    end else begin
      id_q  <= {(fifo_on ? FIFO_TAG : 4'h0), code};
      irq_q <= (code != CODE_NONE);
    end
  end

  assign int_en = en_q;
  assign int_id = id_q;
  assign irq    = irq_q;
endmodule

// File: rtl/uart_int_prioritizer_chk.sv
module uart_int_prioritizer_chk (
  input logic       clk,
  input logic       rst,
  input logic       en_wr,
  input logic [3:0] en_wdata,
  input logic       id_rd,
  input logic       thr_wr,
  input logic       fifo_on,
  input logic [3:0] lsr_err,
  input logic       data_rdy,
  input logic       tmo_pend,
  input logic       thr_empty,
  input logic [3:0] int_en,
  input logic [7:0] int_id,
  input logic       irq
);
  assert_en_load_R2: assert property (@(posedge clk) disable iff (rst)
    en_wr |=> int_en == $past(en_wdata));

  assert_line_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (!en_wr && int_en[2] && (|lsr_err)) |=> int_id[3:0] == 4'h6);

  assert_tmo_gated_R5: assert property (@(posedge clk) disable iff (rst)
    (!en_wr && !int_en[0]) |=> (int_id[3:0] != 4'hC && int_id[3:0] != 4'h4));

  assert_rx_nofifo_R6: assert property (@(posedge clk) disable iff (rst)
    (!en_wr && int_en[0] && !int_en[2] && !tmo_pend && data_rdy && !fifo_on)
      |=> int_id[3:0] == 4'h4);

  assert_thr_wr_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (thr_wr && !en_wr && !thr_empty) |=> int_id[3:0] != 4'h2);

  assert_read_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (id_rd && int_id[3:0] == 4'h2 && !en_wr && !thr_empty) |=> int_id[3:0] != 4'h2);

  assert_fifo_tag_R10: assert property (@(posedge clk) disable iff (rst)
    fifo_on |=> int_id[7:4] == 4'hC);

  assert_irq_match_R11: assert property (@(posedge clk) disable iff (rst)
    irq == (int_id[3:0] != 4'h1));
endmodule

bind uart_int_prioritizer uart_int_prioritizer_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .en_wr     (en_wr),
  .en_wdata  (en_wdata),
  .id_rd     (id_rd),
  .thr_wr    (thr_wr),
  .fifo_on   (fifo_on),
  .lsr_err   (lsr_err),
  .data_rdy  (data_rdy),
  .tmo_pend  (tmo_pend),
  .thr_empty (thr_empty),
  .int_en    (int_en),
  .int_id    (int_id),
  .irq       (irq)
);

// File: tb/uart_int_prioritizer_tb_top.sv
`timescale 1ns/1ps
module uart_int_prioritizer_tb_top;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_wr = 0, id_rd = 0, thr_wr = 0, fifo_on = 0;
  logic data_rdy = 0, tmo_pend = 0, thr_empty = 1;
  logic [3:0] en_wdata = 0, lsr_err = 0, msr_delta = 0;
  logic [CNT_W-1:0] rx_count = 0, rx_trig = 1;
  logic [3:0] int_en;
  logic [7:0] int_id;
  logic irq;

  always #5 clk = ~clk;

  uart_int_prioritizer #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata), .id_rd(id_rd),
    .thr_wr(thr_wr), .fifo_on(fifo_on), .lsr_err(lsr_err), .data_rdy(data_rdy),
    .rx_count(rx_count), .rx_trig(rx_trig), .tmo_pend(tmo_pend),
    .thr_empty(thr_empty), .msr_delta(msr_delta),
    .int_en(int_en), .int_id(int_id), .irq(irq)
  );

  // behavioural reference
  logic [3:0] m_en;
  logic [7:0] m_id;
  bit m_irq, m_pend, m_prev_empty;
  int n_vec = 0, n_bad = 0, cyc = 0;
  string phase = "R1";
  bit done = 0;

  always @(posedge clk) begin
    logic [3:0] ne;
    bit np;
    logic [3:0] c;
    if (rst) begin
      m_en = 0; m_id = 8'h01; m_irq = 0; m_pend = 0; m_prev_empty = 1;
    end else begin
      ne = en_wr ? en_wdata : m_en;
      np = m_pend;
      if (en_wr && (en_wdata[1] != m_en[1])) np = en_wdata[1] && thr_empty;
      else if (thr_wr) np = 0;
      else if (thr_empty && !m_prev_empty) np = 1;
      else if (id_rd && m_id[3:0] == 4'h2) np = 0;
      if (ne[2] && lsr_err != 0) c = 4'h6;
      else if (ne[0] && tmo_pend) c = 4'hC;
      else if (ne[0] && data_rdy && (!fifo_on || rx_count >= rx_trig)) c = 4'h4;
      else if (ne[1] && np) c = 4'h2;
      else if (ne[3] && msr_delta != 0) c = 4'h0;
      else c = 4'h1;
      m_en = ne; m_pend = np; m_prev_empty = thr_empty;
      m_id = {(fifo_on ? 4'hC : 4'h0), c};
      m_irq = (c != 4'h1);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_vec++;
      if (int_en !== m_en || int_id !== m_id || irq !== m_irq) begin
        n_bad++;
        $display("FAIL %s: en=%h id=%h irq=%b expected en=%h id=%h irq=%b",
                 phase, int_en, int_id, irq, m_en, m_id, m_irq);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      en_wr = 0; id_rd = 0; thr_wr = 0;
    end
  endtask

  task automatic wr_en(logic [3:0] v);
    en_wr = 1; en_wdata = v; tick();
  endtask

  task automatic expect_id(logic [7:0] exp, string req);
    #1;
    n_vec++;
    if (int_id !== exp) begin
      n_bad++;
      $display("FAIL %s: id=%h expected %h", req, int_id, exp);
    end
  endtask

  initial begin
    // R1 reset
    tick(3); rst = 0; #0;
    expect_id(8'h01, "R1");
    tick(2);
    phase = "R2";
    wr_en(4'hF); wr_en(4'h5); wr_en(4'h0); wr_en(4'hA); tick();
    wr_en(4'h0); tick();
    phase = "R4";
    wr_en(4'h4);
    for (int b = 0; b < 4; b++) begin lsr_err = 4'b1 << b; tick(); expect_id(8'h06, "R4"); end
    wr_en(4'h0); tick(); lsr_err = 0; tick();
    phase = "R12";
    msr_delta = 4'h3; tick(); wr_en(4'h8); tick(); expect_id(8'h00, "R12");
    msr_delta = 0; tick(2);
    phase = "R6";
    wr_en(4'h1); data_rdy = 1; tick(); expect_id(8'h04, "R6");
    fifo_on = 1; rx_trig = 8; rx_count = 7; tick(); expect_id(8'hC1, "R6");
    rx_count = 8; tick(); expect_id(8'hC4, "R6");
    rx_count = 9; tick(); rx_trig = 14; tick(); rx_count = 16; tick();
    data_rdy = 0; tick();
    phase = "R5";
    tmo_pend = 1; tick(); expect_id(8'hCC, "R5");
    wr_en(4'h0); tick(); expect_id(8'hC1, "R5");
    tmo_pend = 0; fifo_on = 0; tick();
    phase = "R7";
    wr_en(4'h2); tick(); expect_id(8'h02, "R9");
    thr_wr = 1; thr_empty = 0; tick(); tick(); expect_id(8'h01, "R7");
    thr_empty = 1; tick(); expect_id(8'h02, "R7");
    phase = "R8";
    id_rd = 1; tick(); tick(); expect_id(8'h01, "R8");
    wr_en(4'h3); tick(); expect_id(8'h01, "R9");
    wr_en(4'h1); wr_en(4'h2); tick(); expect_id(8'h02, "R9");
    msr_delta = 1; wr_en(4'hA); id_rd = 1; tick(); tick(); expect_id(8'h00, "R8");
    msr_delta = 0; thr_empty = 0; wr_en(4'h0); wr_en(4'h2); tick(); expect_id(8'h01, "R9");
    thr_empty = 1; tick(2);
    phase = "R3";
    wr_en(4'hF); fifo_on = 1; rx_trig = 1; rx_count = 3;
    lsr_err = 4'h2; tmo_pend = 1; data_rdy = 1; msr_delta = 4'h8; tick();
    expect_id(8'hC6, "R3");
    lsr_err = 0; tick(); expect_id(8'hCC, "R3");
    tmo_pend = 0; tick(); expect_id(8'hC4, "R3");
    data_rdy = 0; tick(); expect_id(8'hC2, "R3");
    id_rd = 1; tick(); tick(); expect_id(8'hC0, "R3");
    msr_delta = 0; tick(); expect_id(8'hC1, "R10");
    fifo_on = 0; tick(); expect_id(8'h01, "R10");
    phase = "R11";
    for (int k = 0; k < 3000; k++) begin
      en_wr = ($urandom_range(0, 9) == 0); en_wdata = 4'($urandom);
      id_rd = ($urandom_range(0, 2) == 0); thr_wr = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 5) == 0) thr_empty = ~thr_empty;
      fifo_on = ($urandom_range(0, 15) != 0) ? fifo_on : ~fifo_on;
      lsr_err = ($urandom_range(0, 4) == 0) ? 4'($urandom) : 4'h0;
      data_rdy = 1'($urandom); tmo_pend = ($urandom_range(0, 5) == 0);
      rx_count = CNT_W'($urandom_range(0, 16)); rx_trig = CNT_W'($urandom_range(1, 14));
      msr_delta = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
      @(posedge clk); #2;
      en_wr = 0; id_rd = 0; thr_wr = 0;
    end
    tick(2);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule